// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a small synchronous SRAM. The data word is 32 bits wide and is split into four 8-bit byte lanes. Every command, address, byte-lane mask and write word is captured on the rising clock edge. Read data comes back a fixed two enabled cycles after its address. Write data is taken the same number of cycles after its address. Because reads and writes share that timing, the host can alternate them on every cycle and never needs an idle cycle to turn the bus around.

A cycle with the load strobe low starts a new access. On that cycle the block samples three chip selects and the read/write input. A cycle with the strobe high continues the open burst: the two low address bits step up by one and wrap within a group of four. A continuation keeps the access type and the selection of the load that opened the burst.

There are three inputs that gate the block:
- An active-low clock enable holds every register, as if the previous cycle had been stretched.
- A sleep input makes the block ignore all other inputs and keeps the memory contents.
- An active-low output enable acts asynchronously on the read data drivers.

Top module: `zbt_sram`

## Requirements
- R1: While rst_n is low at a clock edge, all queued accesses are cancelled and the burst state is cleared. After reset, rd_drive is 0 and rd_data is 0 until a read completes.
- R2: A selected read loaded at enabled edge E0 drives the addressed word on rd_data after the second enabled edge that follows E0. rd_drive is 1 in that slot.
- R3: A selected write loaded at enabled edge E0 stores the wr_data present at the second enabled edge after E0. Read and write loads may follow each other on every cycle with no idle cycle between them.
- R4: The byte-lane mask lane_we_n is active low and is sampled with each command. Bit 0 gates data bits 7:0, bit 1 gates 15:8, bit 2 gates 23:16 and bit 3 gates 31:24. When all four bits are low the full word is written; when all four are high nothing is written.
- R5: A cycle with load_n high issues address {upper bits of the previous address, (low 2 bits + 1) mod 4}. The upper address bits stay fixed.
- R6: On a continuation cycle, wr_n and the chip selects are ignored. The burst keeps the type and the selection of its load.
- R7: A load is selected only when cs1_n is 0, cs2 is 1 and cs3_n is 0. An unselected load and its continuations do no access: memory is unchanged and rd_drive stays 0 in their data slot.
- R8: An edge at which clk_en_n is 1 is ignored. All pipeline, burst and output state holds as if the previous cycle continued.
- R9: While sleep is 1, clock edges are ignored and the memory keeps its contents. rd_drive is forced to 0 while sleep is 1.
- R10: While out_en_n is 1, rd_drive is 0 and rd_data is 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; when high the edge is ignored |
| sleep | input | 1 | Sleep, active high; ignores the other inputs and blanks the output |
| load_n | input | 1 | Low loads a new address; high continues the burst |
| wr_n | input | 1 | Access type on a load: 0 write, 1 read |
| cs1_n | input | 1 | Chip select, active low, sampled on a load |
| cs2 | input | 1 | Chip select, active high, sampled on a load |
| cs3_n | input | 1 | Secondary chip select, active low, sampled on a load |
| addr | input | AW | Word address |
| lane_we_n | input | 4 | Byte-lane write mask, active low |
| wr_data | input | 32 | Write word, taken in the data slot of a write |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 32 | Read word; 0 whenever it is not driven |
| rd_drive | output | 1 | High while the read drivers are on |

## Verification
The assertions assume that reset is applied for at least one edge before any access. They also assume that clk_en_n, sleep and the command inputs settle between edges. Under those conditions, the hold and burst-step properties can compare each register with its own previous value.

Every input is driven at the falling edge, and a randomized enable or sleep stall can land in any pipeline slot. Before any random read, every word is written once, so a read never returns an unwritten location. Read and write loads, continuations and deselects are mixed freely, because the reference array tracks them all.

// File: rtl/zbt_pkg.sv
// Shared constants and types for the pipelined SRAM model.
// Assumes a fixed lane geometry; address width is chosen by the top.
package zbt_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int ADDR_W  = 6;
    localparam int BURST_W = 2;
    localparam int LATENCY = 2;

    // One issued command as it travels down the pipeline.
    typedef struct packed {
        logic             valid;
        logic             write;
        logic [LANES-1:0] lanes;
    } zbt_ctl_t;
endpackage

// File: rtl/zbt_cmd_gen.sv
// Command generator: turns load/continue cycles into issued commands.
// Holds the burst state (address, type, selection) between loads.
// Assumes adv is low on stalled or sleeping edges.
module zbt_cmd_gen
    import zbt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = BURST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load_n,
    input  logic             wr_n,
    input  logic             sel_ok,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lane_we_n,
    output zbt_ctl_t         cmd_ctl,
    output logic [AW-1:0]    cmd_addr,
    output logic             burst_act,
    output logic             burst_wr,
    output logic [AW-1:0]    burst_addr
);
    logic [CW-1:0] wrap_next;

    // Next low address bits of a burst, wrapping modulo 2**CW.
    assign wrap_next = burst_addr[CW-1:0] + CW'(1);

    // Choose between a fresh load and a burst continuation.
    always_comb begin
        if (!load_n) begin
            cmd_ctl.valid = sel_ok;
            cmd_ctl.write = !wr_n;
            cmd_addr      = addr;
        end else begin
            cmd_ctl.valid = burst_act;
            cmd_ctl.write = burst_wr;
            cmd_addr      = {burst_addr[AW-1:CW], wrap_next};
        end
        cmd_ctl.lanes = ~lane_we_n;
    end

    // Remember the issued command as the base for the next continuation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_act  <= 1'b0;
            burst_wr   <= 1'b0;
            burst_addr <= '0;
        end else if (adv) begin
            burst_act  <= cmd_ctl.valid;
            burst_wr   <= cmd_ctl.write;
            burst_addr <= cmd_addr;
        end
    end
endmodule

// File: rtl/zbt_pipe.sv
// Command delay line of DEPTH stages, advancing only on enabled edges.
// Assumes only the valid bit needs a reset value.
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DEPTH = LATENCY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  zbt_ctl_t      in_ctl,
    input  logic [AW-1:0] in_addr,
    output zbt_ctl_t      out_ctl,
    output logic [AW-1:0] out_addr,
    output logic          head_valid
);
    zbt_ctl_t      ctl_q  [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        zbt_ctl_t      ctl_d;
        logic [AW-1:0] addr_d;
        if (g == 0) begin : g_first
            assign ctl_d  = in_ctl;
            assign addr_d = in_addr;
        end else begin : g_next
            assign ctl_d  = ctl_q[g-1];
            assign addr_d = addr_q[g-1];
        end

        // Shift one stage forward on each enabled edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[g] <= '0;
            end else if (adv) begin
                ctl_q[g]  <= ctl_d;
                addr_q[g] <= addr_d;
            end
        end
    end

    assign out_ctl    = ctl_q[DEPTH-1];
    assign out_addr   = addr_q[DEPTH-1];
    assign head_valid = ctl_q[0].valid;
endmodule

// File: rtl/zbt_array.sv
// Storage array plus registered read word.
// Performs the data slot of the command leaving the pipeline.
// Assumes memory contents are not reset.
module zbt_array
    import zbt_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  zbt_ctl_t      ctl,
    input  logic [AW-1:0] addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] q_data,
    output logic          q_valid
);
    localparam int DW    = LANES * LANE_W;
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Lane-masked write in the data slot of a write command.
    always_ff @(posedge clk) begin
        if (adv && ctl.valid && ctl.write) begin
            for (int i = 0; i < LANES; i++) begin
                if (ctl.lanes[i])
                    mem[addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
            end
        end
    end

    // Output register loaded in the data slot of a read command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (adv) begin
            q_valid <= ctl.valid && !ctl.write;
            if (ctl.valid && !ctl.write)
                q_data <= mem[addr];
        end
    end
endmodule

// File: rtl/zbt_sram.sv
// Top of the pipelined zero-turnaround SRAM model.
// Stall and sleep share one advance gate; output enable and sleep
// blank the read drivers asynchronously.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LAT = LATENCY
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sleep,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);
    localparam int DW = LANES * LANE_W;

    logic          adv;
    logic          sel_ok;
    zbt_ctl_t      cmd_ctl;
    logic [AW-1:0] cmd_addr;
    logic          burst_act;
    logic          burst_wr;
    logic [AW-1:0] burst_addr;
    zbt_ctl_t      tail_ctl;
    logic [AW-1:0] tail_addr;
    logic          head_valid;
    logic [DW-1:0] q_data;
    logic          q_valid;

    // Edge is honoured only when clock-enabled and awake.
    assign adv    = !clk_en_n && !sleep;
    // All three selects must be true on a load.
    assign sel_ok = !cs1_n && cs2 && !cs3_n;

    zbt_cmd_gen #(.AW(AW), .CW(BURST_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .adv(adv), .load_n(load_n), .wr_n(wr_n),
        .sel_ok(sel_ok), .addr(addr), .lane_we_n(lane_we_n),
        .cmd_ctl(cmd_ctl), .cmd_addr(cmd_addr), .burst_act(burst_act),
        .burst_wr(burst_wr), .burst_addr(burst_addr)
    );

    zbt_pipe #(.AW(AW), .DEPTH(LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_ctl(cmd_ctl),
        .in_addr(cmd_addr), .out_ctl(tail_ctl), .out_addr(tail_addr),
        .head_valid(head_valid)
    );

    zbt_array #(.AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .adv(adv), .ctl(tail_ctl),
        .addr(tail_addr), .wr_data(wr_data), .q_data(q_data),
        .q_valid(q_valid)
    );

    // Asynchronous driver gate on the read word.
    assign rd_drive = q_valid && !out_en_n && !sleep;
    assign rd_data  = rd_drive ? q_data : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
// Property checker for zbt_sram, attached with bind.
// Assumes reset is held for at least one edge before use.
module zbt_sram_chk #(
    parameter int AW = 6,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          sleep,
    input logic          load_n,
    input logic          cs1_n,
    input logic          cs2,
    input logic          cs3_n,
    input logic          out_en_n,
    input logic          rd_drive,
    input logic          q_valid,
    input logic          burst_wr,
    input logic [AW-1:0] burst_addr,
    input logic          head_valid,
    input logic          tail_valid,
    input logic          tail_write
);
    logic go;
    logic picked;
    assign go     = !clk_en_n && !sleep;
    assign picked = !cs1_n && cs2 && !cs3_n;

    a_r10_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rd_drive);

    a_r9_sleep_blank: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rd_drive);

    a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(q_valid) && $stable(burst_addr) && $stable(head_valid));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(q_valid) && $stable(burst_addr)
                     && $stable(burst_wr) && $stable(head_valid));

    a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (go && load_n) |=> (burst_addr[CW-1:0] == $past(burst_addr[CW-1:0]) + CW'(1))
                           && $stable(burst_addr[AW-1:CW]));

    a_r6_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (go && load_n) |=> $stable(burst_wr));

    a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !load_n && !picked) |=> !head_valid);

    a_r2_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (go && tail_valid && !tail_write) |=> q_valid);

    a_r3_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (go && tail_valid && tail_write) |=> !q_valid);
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .CW(zbt_pkg::BURST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
    .load_n(load_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .out_en_n(out_en_n), .rd_drive(rd_drive), .q_valid(q_valid),
    .burst_wr(burst_wr), .burst_addr(burst_addr), .head_valid(head_valid),
    .tail_valid(tail_ctl.valid), .tail_write(tail_ctl.write)
);

// File: tb/sim_zbt_sram.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared against a reference array and pipeline model in the bench.
module sim_zbt_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en_n = 1'b0, sleep = 1'b0, load_n = 1'b0, wr_n = 1'b1;
    logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0, out_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0] lane_we_n = 4'hF;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_drive;

    zbt_sram #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
        .load_n(load_n), .wr_n(wr_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .addr(addr), .lane_we_n(lane_we_n), .wr_data(wr_data),
        .out_en_n(out_en_n), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference state
    logic [DW-1:0] ref_mem [NW];
    logic h_v [2], h_w [2];
    logic [AW-1:0] h_a [2];
    logic [3:0] h_l [2];
    logic b_act = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic exp_qv = 1'b0;
    logic [DW-1:0] exp_q = '0;
    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            h_v[0] = 1'b0; h_v[1] = 1'b0;
            exp_qv = 1'b0; b_act = 1'b0; b_wr = 1'b0; b_addr = '0;
        end else if (!clk_en_n && !sleep) begin
            if (h_v[1] && h_w[1])
                for (int i = 0; i < 4; i++)
                    if (h_l[1][i]) ref_mem[h_a[1]][i*8 +: 8] = wr_data[i*8 +: 8];
            exp_qv = h_v[1] && !h_w[1];
            if (exp_qv) exp_q = ref_mem[h_a[1]];
            h_v[1] = h_v[0]; h_w[1] = h_w[0]; h_a[1] = h_a[0]; h_l[1] = h_l[0];
            if (!load_n) begin
                b_act = !cs1_n && cs2 && !cs3_n;
                b_wr = !wr_n;
                b_addr = addr;
            end else begin
                b_addr = {b_addr[AW-1:2], b_addr[1:0] + 2'd1};
            end
            h_v[0] = b_act; h_w[0] = b_wr; h_a[0] = b_addr; h_l[0] = ~lane_we_n;
        end
    endtask

    // One clock: new write word, edge, model update, check at falling edge.
    task automatic tick(input string tag);
        logic drv;
        wr_data = $urandom();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        drv = exp_qv && !out_en_n && !sleep;
        chk({tag, " drive"}, {31'b0, rd_drive}, {31'b0, drv});
        chk({tag, " data"}, rd_data, drv ? exp_q : '0);
    endtask

    task automatic cmd(input logic ld_n, input logic w_n, input logic [AW-1:0] a,
                       input logic [3:0] ln);
        load_n = ld_n; wr_n = w_n; addr = a; lane_we_n = ln;
    endtask

    initial begin
        h_v[0] = 1'b0; h_v[1] = 1'b0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset clears pipeline and output
        for (int i = 0; i < 3; i++) tick("R1 reset");
        rst_n = 1'b1;
        cmd(1'b0, 1'b1, '0, 4'hF); cs2 = 1'b0;
        tick("R1 after reset");
        cs2 = 1'b1;
        // R3: fill every word with full-lane writes back to back
        for (int i = 0; i < NW; i++) begin
            cmd(1'b0, 1'b0, AW'(i), 4'h0);
            tick("R3 fill");
        end
        // R2/R3 alternation with no idle cycle
        for (int i = 0; i < 16; i++) begin
            cmd(1'b0, i[0], AW'(i % 4), 4'h0);
            tick("R3 alternate");
        end
        for (int i = 0; i < 4; i++) begin
            cmd(1'b0, 1'b1, AW'(i), 4'hF);
            tick("R2 read latency");
        end
        // R4: partial lane writes, then read back
        cmd(1'b0, 1'b0, 6'd3, 4'b1010); tick("R4 lanes a,c");
        cmd(1'b0, 1'b0, 6'd4, 4'b1111); tick("R4 no lanes");
        cmd(1'b0, 1'b0, 6'd5, 4'b0111); tick("R4 lane d");
        cmd(1'b0, 1'b1, 6'd3, 4'hF); tick("R4 read");
        cmd(1'b0, 1'b1, 6'd4, 4'hF); tick("R4 read");
        cmd(1'b0, 1'b1, 6'd5, 4'hF); tick("R4 read");
        // R5: read burst from low bits 2, wrapping past 3
        cmd(1'b0, 1'b1, 6'b010110, 4'hF); tick("R5 burst load");
        for (int i = 0; i < 5; i++) begin
            cmd(1'b1, i[0], 6'b111111, 4'hF);
            tick("R5 burst wrap");
        end
        // R6: write burst while wr_n and selects toggle
        cmd(1'b0, 1'b0, 6'b100001, 4'h0); tick("R6 write load");
        for (int i = 0; i < 3; i++) begin
            cmd(1'b1, 1'b1, 6'd0, 4'h0); cs2 = i[0];
            tick("R6 continue ignores type");
        end
        cs2 = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cmd(1'b0, 1'b1, AW'(32 + i), 4'hF); tick("R6 readback");
        end
        // R7: deselected write and its continuation leave memory alone
        cmd(1'b0, 1'b0, 6'd9, 4'h0); cs3_n = 1'b1; tick("R7 deselect write");
        cs3_n = 1'b0; cmd(1'b1, 1'b0, 6'd0, 4'h0); tick("R7 deselect continue");
        cmd(1'b0, 1'b1, 6'd9, 4'hF); cs1_n = 1'b1; tick("R7 deselect read");
        cs1_n = 1'b0;
        cmd(1'b0, 1'b1, 6'd9, 4'hF); tick("R7 readback");
        cmd(1'b0, 1'b1, 6'd10, 4'hF); tick("R7 readback");
        tick("R7 readback");
        // R8: stall with reads in flight
        cmd(1'b0, 1'b1, 6'd12, 4'hF); tick("R8 load");
        cmd(1'b0, 1'b1, 6'd13, 4'hF); tick("R8 load");
        clk_en_n = 1'b1; cmd(1'b0, 1'b0, 6'd12, 4'h0);
        for (int i = 0; i < 3; i++) tick("R8 stall hold");
        clk_en_n = 1'b0; cmd(1'b0, 1'b1, 6'd14, 4'hF);
        for (int i = 0; i < 3; i++) tick("R8 resume");
        // R9: sleep with a read in flight
        cmd(1'b0, 1'b1, 6'd15, 4'hF); tick("R9 load");
        tick("R9 load");
        sleep = 1'b1; cmd(1'b0, 1'b0, 6'd15, 4'h0);
        for (int i = 0; i < 3; i++) tick("R9 asleep");
        sleep = 1'b0; cmd(1'b0, 1'b1, 6'd15, 4'hF);
        for (int i = 0; i < 3; i++) tick("R9 awake");
        // R10: output enable off while a read lands
        cmd(1'b0, 1'b1, 6'd16, 4'hF); tick("R10 load");
        tick("R10 load");
        out_en_n = 1'b1; tick("R10 blanked");
        out_en_n = 1'b0; #1;
        chk("R10 async drive", {31'b0, rd_drive}, {31'b0, exp_qv});
        tick("R10 restored");
        // Seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            cmd(($urandom() % 10) < 3, $urandom() % 2, AW'($urandom()), 4'($urandom()));
            if (($urandom() % 10) == 0) lane_we_n = 4'h0;
            clk_en_n = ($urandom() % 10) == 0;
            sleep    = ($urandom() % 30) == 0;
            out_en_n = ($urandom() % 10) == 0;
            cs1_n    = ($urandom() % 20) == 0;
            cs2      = ($urandom() % 20) != 0;
            cs3_n    = ($urandom() % 20) == 0;
            tick("random R3 mix");
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule